// File: doc/BRIEF.md
# Versioned Frame Builder and Checker with CRC-32 Trailer

This block wraps one packet for a shared transfer buffer and checks one packet read back from it. The transmit half takes the packet bytes (the complete packet, its own header included) and produces a frame. The frame starts with a byte count, carries the packet bytes, and ends with a CRC-32 trailer only when the negotiated protocol version asks for one. The receive half reads such a frame. It recovers the count, forwards the packet bytes and, when a trailer is present, compares it with its own CRC. It then reports the result with a one-cycle done pulse.

The negotiated version is a plain input, sampled once per frame. Each half handles one frame and then returns to its starting state, ready for the next. All byte streams use valid/ready handshakes. A byte moves only in a cycle where both valid and ready are high. A source must hold valid and data steady until the byte is taken. Back-pressure from the consumer of packet bytes passes straight through to the producer, so both stall together. Header and trailer bytes need no producer and are gated only by the downstream ready.

Top module: `pkt_frame_crc`

## Requirements
- R1: A frame begins with a 4-byte count, most significant byte first. The count equals the number of packet bytes and excludes any trailer; for transmit it is `tx_len` as given at the start.
- R2: A trailer follows the last packet byte only when the version input equals 3. For any other value (1 and 2 included) the frame ends with the last packet byte.
- R3: The trailer is the CRC-32 of the packet bytes, sent and expected least significant byte first. The CRC uses remainder init 0xFFFFFFFF, the reflected polynomial 0xEDB88320 applied LSB first and one byte per cycle, and a final XOR with 0xFFFFFFFF. A zero-length packet has trailer 0x00000000, and the packet "123456789" has trailer 0xCBF43926.
- R4: After reset, and after each frame completes, both halves are idle. `tx_busy` is low, no output byte is offered, `rx_in_ready` is high, and the next received byte is parsed as the first count byte of a new frame.
- R5: On every stream a byte transfers only when valid and ready are both high. While the transmitter offers a byte that is not taken, it keeps it unchanged. Packet bytes pass in order with back-pressure carried across both directions.
- R6: The receiver forwards the packet bytes in order on the payload stream. It pulses `rx_done` for one cycle, in the cycle after the final byte of the frame is accepted. `rx_crc_ok` is 1 there if the received trailer matches the computed CRC. It is always 1 when there is no trailer.
- R7: A `tx_start` with `tx_len` greater than parameter `MTU` starts no frame. `tx_len_err` pulses for one cycle in the next cycle, `tx_busy` stays low and nothing is emitted.
- R8: A received count greater than `MTU` pulses `rx_len_err` in the cycle after the last count byte. The receiver then absorbs the count's packet bytes (plus 4 trailer bytes when the version is 3) with `rx_in_ready` high. It forwards none of them, gives no `rx_done`, and parses the following byte as a new frame.
- R9: The version is sampled when a frame begins: at an accepted `tx_start` for transmit and at the first count byte for receive. Later changes do not alter that frame.
- R10: `tx_start` is ignored while `tx_busy` is high; the frame in flight is emitted unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ver | input | 2 | Negotiated protocol version |
| tx_start | input | 1 | Begin a transmit frame of `tx_len` bytes |
| tx_len | input | LEN_W | Packet byte count for the frame being started |
| tx_in_valid | input | 1 | Packet byte available from producer |
| tx_in_ready | output | 1 | Framer takes the packet byte |
| tx_in_data | input | 8 | Packet byte from producer |
| tx_out_valid | output | 1 | Frame byte offered downstream |
| tx_out_ready | input | 1 | Downstream takes the frame byte |
| tx_out_data | output | 8 | Frame byte |
| tx_busy | output | 1 | A transmit frame is in progress |
| tx_len_err | output | 1 | Pulse: rejected start, count above MTU |
| rx_in_valid | input | 1 | Received frame byte available |
| rx_in_ready | output | 1 | Checker takes the frame byte |
| rx_in_data | input | 8 | Received frame byte |
| rx_pay_valid | output | 1 | Packet byte offered to consumer |
| rx_pay_ready | input | 1 | Consumer takes the packet byte |
| rx_pay_data | output | 8 | Packet byte |
| rx_done | output | 1 | Pulse: frame complete |
| rx_crc_ok | output | 1 | Trailer check result, valid with `rx_done` |
| rx_len_err | output | 1 | Pulse: received count above MTU |

## Verification
The bench builds the block with `LEN_W` = 32 and `MTU` = 12. With that limit a 13-byte start and a 20-byte received count both reach the oversize paths within a few dozen cycles. The frames used stay short enough to follow every byte, and a 9-byte packet still fits, so the standard check string can be run against its known CRC. The drop path is followed by a valid frame in the same stream, which shows that the receiver resumes at the correct byte after an oversize count.

// File: rtl/frame_pkg.sv
package frame_pkg;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT  = 32'hFFFFFFFF;
  localparam int          CRC_BYTES = 4;
  localparam logic [1:0]  VER_CRC   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_TRL,
    ST_DROP
  } fr_state_e;
endpackage

// File: rtl/crc32_byte_step.sv
module crc32_byte_step
  import frame_pkg::*;
(
  input  logic [31:0] crc_in,
  input  logic [7:0]  data_in,
  output logic [31:0] crc_out
);
  logic [31:0] c;

  // one byte, bit by bit, least significant bit first
  always_comb begin
    c = crc_in ^ {24'h0, data_in};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    crc_out = c;
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int MTU   = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ver,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             busy,
  output logic             len_err
);
  localparam int               HDR_BYTES = LEN_W / 8;
  localparam logic [LEN_W-1:0] HDR_LAST  = LEN_W'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] TRL_LAST  = LEN_W'(CRC_BYTES - 1);
  localparam logic [LEN_W-1:0] MTU_L     = LEN_W'(MTU);

  fr_state_e        st;
  logic [LEN_W-1:0] len_q, hdr_sr, cnt;
  logic [31:0]      crc_q, crc_nx, trl_sr;
  logic             crc_en_q, err_q;

  crc32_byte_step u_crc (.crc_in(crc_q), .data_in(in_data), .crc_out(crc_nx));

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    in_ready  = 1'b0;
    unique case (st)
      ST_HDR: begin
        out_valid = 1'b1;
        out_data  = hdr_sr[LEN_W-1 -: 8];
      end
      ST_PAY: begin
        out_valid = in_valid;
        out_data  = in_data;
        in_ready  = out_ready;
      end
      ST_TRL: begin
        out_valid = 1'b1;
        out_data  = trl_sr[7:0];
      end
      default: ;
    endcase
  end

  assign busy    = (st != ST_IDLE);
  assign len_err = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      len_q    <= '0;
      hdr_sr   <= '0;
      cnt      <= '0;
      crc_q    <= CRC_INIT;
      trl_sr   <= '0;
      crc_en_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          if (len > MTU_L) begin
            err_q <= 1'b1;
          end else begin
            st       <= ST_HDR;
            len_q    <= len;
            hdr_sr   <= len;
            cnt      <= '0;
            crc_q    <= CRC_INIT;
            crc_en_q <= (ver == VER_CRC);
          end
        end
        ST_HDR: if (out_ready) begin
          hdr_sr <= hdr_sr << 8;
          if (cnt == HDR_LAST) begin
            cnt <= '0;
            if (len_q != '0) begin
              st <= ST_PAY;
            end else if (crc_en_q) begin
              st     <= ST_TRL;
              trl_sr <= ~crc_q;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAY: if (in_valid && out_ready) begin
          crc_q <= crc_nx;
          if (cnt == len_q - 1'b1) begin
            cnt <= '0;
            if (crc_en_q) begin
              st     <= ST_TRL;
              trl_sr <= ~crc_nx;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TRL: if (out_ready) begin
          trl_sr <= trl_sr >> 8;
          if (cnt == TRL_LAST) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frame_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int MTU   = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ver,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       pay_valid,
  input  logic       pay_ready,
  output logic [7:0] pay_data,
  output logic       done,
  output logic       crc_ok,
  output logic       len_err
);
  localparam int               HDR_BYTES = LEN_W / 8;
  localparam logic [LEN_W-1:0] HDR_LAST  = LEN_W'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] TRL_LAST  = LEN_W'(CRC_BYTES - 1);
  localparam logic [LEN_W-1:0] MTU_L     = LEN_W'(MTU);
  localparam logic [LEN_W:0]   TRL_CNT   = (LEN_W+1)'(CRC_BYTES);
  localparam logic [LEN_W:0]   ONE_W     = (LEN_W+1)'(1);

  fr_state_e        st;
  logic [LEN_W-1:0] len_sr, len_nx, cnt;
  logic [LEN_W:0]   drop_left;
  logic [31:0]      crc_q, crc_nx, fin_sr;
  logic             crc_en_q, en_now, bad_q, bad_nx;
  logic             done_q, ok_q, lerr_q;

  crc32_byte_step u_crc (.crc_in(crc_q), .data_in(in_data), .crc_out(crc_nx));

  assign in_ready  = (st == ST_PAY) ? pay_ready : 1'b1;
  assign pay_valid = (st == ST_PAY) && in_valid;
  assign pay_data  = in_data;
  assign len_nx    = {len_sr[LEN_W-9:0], in_data};
  assign en_now    = (cnt == '0) ? (ver == VER_CRC) : crc_en_q;
  assign bad_nx    = bad_q | (in_data != fin_sr[7:0]);
  assign done      = done_q;
  assign crc_ok    = ok_q;
  assign len_err   = lerr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_HDR;
      len_sr    <= '0;
      cnt       <= '0;
      drop_left <= '0;
      crc_q     <= CRC_INIT;
      fin_sr    <= '0;
      crc_en_q  <= 1'b0;
      bad_q     <= 1'b0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      lerr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      lerr_q <= 1'b0;
      unique case (st)
        ST_HDR: if (in_valid) begin
          len_sr <= len_nx;
          if (cnt == '0) crc_en_q <= (ver == VER_CRC);
          if (cnt == HDR_LAST) begin
            cnt   <= '0;
            crc_q <= CRC_INIT;
            bad_q <= 1'b0;
            if (len_nx > MTU_L) begin
              lerr_q    <= 1'b1;
              st        <= ST_DROP;
              drop_left <= {1'b0, len_nx} + (en_now ? TRL_CNT : '0) - ONE_W;
            end else if (len_nx != '0) begin
              st <= ST_PAY;
            end else if (en_now) begin
              st     <= ST_TRL;
              fin_sr <= ~CRC_INIT;
            end else begin
              done_q <= 1'b1;
              ok_q   <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAY: if (in_valid && pay_ready) begin
          crc_q <= crc_nx;
          if (cnt == len_sr - 1'b1) begin
            cnt <= '0;
            if (crc_en_q) begin
              st     <= ST_TRL;
              fin_sr <= ~crc_nx;
            end else begin
              st     <= ST_HDR;
              done_q <= 1'b1;
              ok_q   <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TRL: if (in_valid) begin
          fin_sr <= fin_sr >> 8;
          if (cnt == TRL_LAST) begin
            cnt    <= '0;
            st     <= ST_HDR;
            done_q <= 1'b1;
            ok_q   <= !bad_nx;
          end else begin
            bad_q <= bad_nx;
            cnt   <= cnt + 1'b1;
          end
        end
        ST_DROP: if (in_valid) begin
          if (drop_left == '0) st <= ST_HDR;
          else drop_left <= drop_left - ONE_W;
        end
        default: st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/pkt_frame_crc.sv
module pkt_frame_crc
  import frame_pkg::*;
#(
  parameter int LEN_W = 32,
  parameter int MTU   = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ver,
  input  logic             tx_start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [7:0]       tx_in_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [7:0]       tx_out_data,
  output logic             tx_busy,
  output logic             tx_len_err,
  input  logic             rx_in_valid,
  output logic             rx_in_ready,
  input  logic [7:0]       rx_in_data,
  output logic             rx_pay_valid,
  input  logic             rx_pay_ready,
  output logic [7:0]       rx_pay_data,
  output logic             rx_done,
  output logic             rx_crc_ok,
  output logic             rx_len_err
);
  frame_tx #(.LEN_W(LEN_W), .MTU(MTU)) u_tx (
    .clk(clk), .rst_n(rst_n), .ver(ver),
    .start(tx_start), .len(tx_len),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .busy(tx_busy), .len_err(tx_len_err)
  );

  frame_rx #(.LEN_W(LEN_W), .MTU(MTU)) u_rx (
    .clk(clk), .rst_n(rst_n), .ver(ver),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .pay_valid(rx_pay_valid), .pay_ready(rx_pay_ready), .pay_data(rx_pay_data),
    .done(rx_done), .crc_ok(rx_crc_ok), .len_err(rx_len_err)
  );
endmodule

// File: rtl/pkt_frame_crc_chk.sv
module pkt_frame_crc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_start,
  input logic       tx_out_valid,
  input logic       tx_out_ready,
  input logic [7:0] tx_out_data,
  input logic       tx_busy,
  input logic       tx_len_err,
  input logic       rx_done,
  input logic       rx_len_err
);
  // R5: an offered frame byte that is not taken stays put
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_data));

  // R4: nothing is offered while idle
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_out_valid);

  // R7: a rejected start leaves the framer idle
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_len_err |-> !tx_busy);

  // R10: a frame begins only from a start request
  a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_start));

  // R8: an oversize count never ends in a done pulse right after
  a_r8_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    rx_len_err |=> !rx_done);

  // R6: done is a single-cycle pulse per frame
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
endmodule

bind pkt_frame_crc pkt_frame_crc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_start(tx_start),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_data(tx_out_data), .tx_busy(tx_busy), .tx_len_err(tx_len_err),
  .rx_done(rx_done), .rx_len_err(rx_len_err)
);

// File: tb/pkt_frame_crc_bench.sv
module pkt_frame_crc_bench;
  localparam int LEN_W = 32;
  localparam int MTU   = 12;

  logic clk = 0, rst_n = 0;
  logic [1:0] ver = 2'd1;
  logic tx_start = 0;
  logic [LEN_W-1:0] tx_len = '0;
  logic tx_in_valid = 0, tx_in_ready;
  logic [7:0] tx_in_data = 0;
  logic tx_out_valid, tx_out_ready = 0;
  logic [7:0] tx_out_data;
  logic tx_busy, tx_len_err;
  logic rx_in_valid = 0, rx_in_ready;
  logic [7:0] rx_in_data = 0;
  logic rx_pay_valid, rx_pay_ready = 0;
  logic [7:0] rx_pay_data;
  logic rx_done, rx_crc_ok, rx_len_err;

  int checks = 0, errors = 0;
  logic [7:0] pay  [0:31];
  logic [7:0] fb   [0:95];
  logic [7:0] got  [0:95];
  logic [7:0] xp   [0:95];
  int fn, xn, gn;

  always #5 clk = ~clk;

  pkt_frame_crc #(.LEN_W(LEN_W), .MTU(MTU)) u_pkt_frame_crc (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, pay[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // frame layout: 4-byte big-endian count, packet, CRC LSB first if v==3
  task automatic add_frame(input logic [1:0] v, input int n, input int cnt_field,
                           input bit corrupt, input bit fwd);
    logic [31:0] c = crc_ref(n);
    for (int i = 3; i >= 0; i--) begin fb[fn] = 8'(cnt_field >> (8*i)); fn++; end
    for (int i = 0; i < n; i++) begin
      fb[fn] = pay[i]; fn++;
      if (fwd) begin xp[xn] = pay[i]; xn++; end
    end
    if (v == 2'd3) for (int i = 0; i < 4; i++) begin
      fb[fn] = c[8*i +: 8] ^ ((corrupt && i == 2) ? 8'h01 : 8'h00); fn++;
    end
  endtask

  task automatic run_tx(input logic [1:0] v, input int n, input bit stall,
                        input logic [1:0] v_mid, input bit glitch, input string tag);
    int si = 0, errs = 0, nexp;
    logic [31:0] c = crc_ref(n);
    bit over = (n > MTU);
    xn = 0; gn = 0;
    for (int i = 3; i >= 0; i--) begin xp[xn] = 8'(n >> (8*i)); xn++; end
    for (int i = 0; i < n; i++) begin xp[xn] = pay[i]; xn++; end
    if (v == 2'd3) for (int i = 0; i < 4; i++) begin xp[xn] = c[8*i +: 8]; xn++; end
    nexp = over ? 0 : xn;
    @(negedge clk); ver = v; tx_start = 1; tx_len = n;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      tx_start = glitch && (k == 3);
      tx_len   = (glitch && k == 3) ? 2 : n;
      if (k == 2) ver = v_mid;
      tx_out_ready = !stall || (k % 3 != 0);
      tx_in_valid  = !over && (si < n);
      tx_in_data   = pay[si];
      #1;
      if (tx_len_err) errs++;
      if (tx_out_valid && tx_out_ready) begin got[gn] = tx_out_data; gn++; end
      if (tx_in_valid && tx_in_ready) si++;
    end
    tx_in_valid = 0;
    chk(tx_busy == 0, {tag, " R4 idle after frame"}, tx_busy, 0);
    chk(gn == nexp, {tag, " R1/R2 byte count"}, gn, nexp);
    chk(errs == (over ? 1 : 0), {tag, " R7 len_err pulses"}, errs, over);
    for (int i = 0; i < nexp && i < gn; i++)
      chk(got[i] == xp[i], {tag, " R1 R3 R5 frame byte"}, got[i], xp[i]);
  endtask

  task automatic run_rx(input logic [1:0] v, input bit stall, input int ndone,
                        input bit ok_exp, input int nlerr, input string tag);
    int fi = 0, dn = 0, le = 0;
    bit okv = 0;
    gn = 0;
    @(negedge clk); ver = v;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      rx_in_valid  = (fi < fn);
      rx_in_data   = fb[fi];
      rx_pay_ready = !stall || (k % 3 != 1);
      #1;
      if (rx_done) begin dn++; okv = rx_crc_ok; end
      if (rx_len_err) le++;
      if (rx_pay_valid && rx_pay_ready) begin got[gn] = rx_pay_data; gn++; end
      if (rx_in_valid && rx_in_ready) fi++;
    end
    rx_in_valid = 0;
    chk(fi == fn, {tag, " R5 all bytes absorbed"}, fi, fn);
    chk(dn == ndone, {tag, " R6 done pulses"}, dn, ndone);
    if (ndone > 0) chk(okv == ok_exp, {tag, " R6 crc_ok"}, okv, ok_exp);
    chk(le == nlerr, {tag, " R8 len_err pulses"}, le, nlerr);
    chk(gn == xn, {tag, " R6 R8 payload count"}, gn, xn);
    for (int i = 0; i < xn && i < gn; i++)
      chk(got[i] == xp[i], {tag, " R6 payload byte"}, got[i], xp[i]);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(tx_busy == 0, "R4 reset busy", tx_busy, 0);
    chk(tx_out_valid == 0, "R4 reset tx_out_valid", tx_out_valid, 0);
    chk(rx_in_ready == 1, "R4 reset rx_in_ready", rx_in_ready, 1);
    chk(rx_done == 0 && rx_len_err == 0, "R4 reset rx pulses", rx_done, 0);
    rst_n = 1;
  endtask

  task automatic t_check_string;
    string s = "123456789";
    for (int i = 0; i < 9; i++) pay[i] = s[i];
    run_tx(2'd3, 9, 1, 2'd3, 1, "tx v3 check string stall glitch R10");
    chk({got[16], got[15], got[14], got[13]} == 32'hCBF43926, "R3 known CRC value",
        {got[16], got[15], got[14], got[13]}, 32'hCBF43926);
  endtask

  initial begin
    t_reset();
    for (int i = 0; i < 32; i++) pay[i] = 8'(8'hA5 ^ (i * 37));
    run_tx(2'd1, 5, 0, 2'd1, 0, "tx v1 R2");
    run_tx(2'd2, 12, 1, 2'd2, 0, "tx v2 at MTU R2");
    run_tx(2'd3, 0, 0, 2'd3, 0, "tx v3 empty R3");
    run_tx(2'd3, 13, 0, 2'd3, 0, "tx oversize R7");
    run_tx(2'd3, 6, 0, 2'd1, 0, "tx version change R9");
    t_check_string();
    for (int i = 0; i < 32; i++) pay[i] = 8'(i * 13 + 7);
    fn = 0; xn = 0; add_frame(2'd3, 7, 7, 0, 1);
    run_rx(2'd3, 1, 1, 1, 0, "rx v3 good R6");
    fn = 0; xn = 0; add_frame(2'd3, 7, 7, 1, 1);
    run_rx(2'd3, 0, 1, 0, 0, "rx v3 bad trailer R6");
    fn = 0; xn = 0; add_frame(2'd2, 4, 4, 0, 1); add_frame(2'd2, 2, 2, 0, 1);
    run_rx(2'd2, 1, 2, 1, 0, "rx v2 back to back R4");
    fn = 0; xn = 0; add_frame(2'd3, 0, 0, 0, 1);
    run_rx(2'd3, 0, 1, 1, 0, "rx v3 empty R3");
    fn = 0; xn = 0; add_frame(2'd3, 20, 20, 0, 0); add_frame(2'd3, 3, 3, 0, 1);
    run_rx(2'd3, 0, 1, 1, 1, "rx oversize drop R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule